// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Busy Arbitration

This block is a synchronous two-port memory of 2048 words, 16 bits each, with a left port and a right port that run independently on one clock. Each port has an active-low enable, an active-low output enable and two active-low byte write strobes, one for the low byte (bits 7:0) and one for the high byte (bits 15:8). In one access, a byte whose strobe is low is written and a byte whose strobe is high is read. A port can therefore write one byte and read the other in the same cycle. Pins that would be three-state are modelled as a data bus with one valid flag per byte lane.

When both ports are enabled on the same address, an arbiter pulls an active-low busy flag on the port that formed the match later. That port's writes are dropped. The arbiter decides the order at the clock edge where the match appears. If both ports arrive in the same cycle, the left port wins. A parameter sets the role of the busy pins. In master mode the busy outputs come from the arbiter and the busy inputs are ignored. In slave mode the busy outputs stay high and the busy inputs inhibit writes.

Top module: `dpram_busy_arb`

## Requirements
- R1: At a rising edge with enable low and busy inactive, each byte lane whose write strobe is low stores its data byte (low byte = bits 7:0, high byte = bits 15:8). A later read returns the stored bytes.
- R2: At an edge where a port's enable is high, that port writes nothing, and in the next cycle both of its byte valid flags are low.
- R3: With enable low, write strobe high and output enable low, a byte lane presents the stored byte on read data with its valid flag high one cycle after the edge. With output enable high, both valid flags are low.
- R4: In one access, a port can write one byte and read the other. The read byte returns the value stored before that edge.
- R5: Both busy flags are high when the addresses differ or when either enable is high.
- R6: On an address match the busy flag goes low on the port whose enable or address changed later, and the other flag stays high. Busy stays low while both ports hold their inputs, and returns high in the same cycle the match ends.
- R7: If both ports form the match in the same cycle, the right port's busy goes low and the left port's stays high.
- R8: The two busy flags are never low at the same time.
- R9: A write from a port whose busy is low changes neither byte lane.
- R10: In slave mode both busy outputs stay high, and a low busy input blocks writes on that port. In master mode the busy inputs have no effect.
- R11: A read issued while the port's busy is low sets that port's suspect flag alongside the valid flags in the next cycle. Otherwise the suspect flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en_n | input | 1 | Left enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wr_lo_n | input | 1 | Left low byte write strobe, active low |
| l_wr_hi_n | input | 1 | Left high byte write strobe, active low |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_rvld_lo | output | 1 | Left low byte read valid |
| l_rvld_hi | output | 1 | Left high byte read valid |
| l_rd_suspect | output | 1 | Left read taken during busy |
| l_busy_n_o | output | 1 | Left busy from arbiter, active low |
| l_busy_n_i | input | 1 | Left busy input for slave mode, active low |
| r_en_n | input | 1 | Right enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wr_lo_n | input | 1 | Right low byte write strobe, active low |
| r_wr_hi_n | input | 1 | Right high byte write strobe, active low |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_rvld_lo | output | 1 | Right low byte read valid |
| r_rvld_hi | output | 1 | Right high byte read valid |
| r_rd_suspect | output | 1 | Right read taken during busy |
| r_busy_n_o | output | 1 | Right busy from arbiter, active low |
| r_busy_n_i | input | 1 | Right busy input for slave mode, active low |

## Verification
Some properties are checked by assertions on every clock: the busy flags are never low together, busy is low only during a real address match, busy stays put while a match is held, a disabled port shows no valid byte, and no write strobe reaches the array while a port is inhibited. Other behaviour only the bench scenarios can show. These are who loses when one port arrives later and who loses when both arrive together, that a dropped write leaves the old word in place, the mixed byte read and write, and the slave-mode inhibit. A behavioural model compares busy flags, valid flags, suspect flags and read bytes on every cycle, including during a long run of random accesses over four addresses.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic [1:0] {
    LOSER_NONE = 2'd0,
    LOSER_L    = 2'd1,
    LOSER_R    = 2'd2
  } loser_e;

  // A collision needs both ports enabled on the same word.
  function automatic logic ports_collide(input logic en_l_n, input logic en_r_n,
                                         input logic addr_eq);
    return !en_l_n && !en_r_n && addr_eq;
  endfunction

  // The port that changed into the match loses. A tie goes to the left port.
  function automatic loser_e pick_loser(input logic match, input logic l_new,
                                        input logic r_new, input loser_e held);
    if (!match)               return LOSER_NONE;
    else if (!l_new && !r_new) return held;
    else if (l_new && !r_new)  return LOSER_L;
    else                       return LOSER_R;
  endfunction

endpackage

// File: rtl/dpb_arbiter.sv
module dpb_arbiter
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              collide
);

  logic              l_en_q, r_en_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  loser_e            loser_q, loser_d;
  logic              l_new, r_new;
  logic              armed;

  assign collide  = ports_collide(l_en_n, r_en_n, l_addr == r_addr);
  assign l_new    = (l_en_n != l_en_q) || (l_addr != l_addr_q);
  assign r_new    = (r_en_n != r_en_q) || (r_addr != r_addr_q);
  assign loser_d  = pick_loser(collide, l_new, r_new, loser_q);
  assign l_busy_n = (loser_d != LOSER_L);
  assign r_busy_n = (loser_d != LOSER_R);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b1;
      r_en_q   <= 1'b1;
      l_addr_q <= '0;
      r_addr_q <= '0;
      loser_q  <= LOSER_NONE;
      armed    <= 1'b0;
    end else begin
      l_en_q   <= l_en_n;
      r_en_q   <= r_en_n;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      loser_q  <= loser_d;
      armed    <= 1'b1;
    end
  end

  a_r8_never_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  a_r5_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> (!l_en_n && !r_en_n && (l_addr == r_addr)));

  a_r6_held_match_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(collide) && $stable(l_addr) && $stable(r_addr) &&
     $stable(l_en_n) && $stable(r_en_n)) |-> ($stable(l_busy_n) && $stable(r_busy_n)));

endmodule

// File: rtl/dpb_port_ctrl.sv
module dpb_port_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_n,
  input  logic       oe_n,
  input  logic       wr_lo_n,
  input  logic       wr_hi_n,
  input  logic       wr_allow,
  output logic [1:0] we,
  output logic       rvld_lo,
  output logic       rvld_hi,
  output logic       rd_suspect
);

  logic rd_lo, rd_hi;

  assign we[0] = !en_n && !wr_lo_n && wr_allow;
  assign we[1] = !en_n && !wr_hi_n && wr_allow;
  assign rd_lo = !en_n && wr_lo_n && !oe_n;
  assign rd_hi = !en_n && wr_hi_n && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_lo    <= 1'b0;
      rvld_hi    <= 1'b0;
      rd_suspect <= 1'b0;
    end else begin
      rvld_lo    <= rd_lo;
      rvld_hi    <= rd_hi;
      rd_suspect <= (rd_lo || rd_hi) && !wr_allow;
    end
  end

  a_r2_disabled_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> (!rvld_lo && !rvld_hi));

  a_r11_suspect_only_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_suspect |-> (rvld_lo || rvld_hi));

endmodule

// File: rtl/dpb_array.sv
module dpb_array #(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       l_addr,
  input  logic                    l_rd,
  input  logic [LANES-1:0]        l_we,
  input  logic [LANES*BYTE_W-1:0] l_wdata,
  output logic [LANES*BYTE_W-1:0] l_rdata,
  input  logic [ADDR_W-1:0]       r_addr,
  input  logic                    r_rd,
  input  logic [LANES-1:0]        r_we,
  input  logic [LANES*BYTE_W-1:0] r_wdata,
  output logic [LANES*BYTE_W-1:0] r_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] l_q, r_q;

    always_ff @(posedge clk) begin
      if (l_rd) l_q <= mem[l_addr];
      if (r_rd) r_q <= mem[r_addr];
      if (l_we[g]) mem[l_addr] <= l_wdata[g*BYTE_W +: BYTE_W];
      if (r_we[g]) mem[r_addr] <= r_wdata[g*BYTE_W +: BYTE_W];
    end

    assign l_rdata[g*BYTE_W +: BYTE_W] = l_q;
    assign r_rdata[g*BYTE_W +: BYTE_W] = r_q;
  end

endmodule

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb #(
  parameter int ADDR_W    = 11,
  parameter int BYTE_W    = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                l_en_n,
  input  logic                l_oe_n,
  input  logic                l_wr_lo_n,
  input  logic                l_wr_hi_n,
  input  logic [ADDR_W-1:0]   l_addr,
  input  logic [2*BYTE_W-1:0] l_wdata,
  output logic [2*BYTE_W-1:0] l_rdata,
  output logic                l_rvld_lo,
  output logic                l_rvld_hi,
  output logic                l_rd_suspect,
  output logic                l_busy_n_o,
  input  logic                l_busy_n_i,
  input  logic                r_en_n,
  input  logic                r_oe_n,
  input  logic                r_wr_lo_n,
  input  logic                r_wr_hi_n,
  input  logic [ADDR_W-1:0]   r_addr,
  input  logic [2*BYTE_W-1:0] r_wdata,
  output logic [2*BYTE_W-1:0] r_rdata,
  output logic                r_rvld_lo,
  output logic                r_rvld_hi,
  output logic                r_rd_suspect,
  output logic                r_busy_n_o,
  input  logic                r_busy_n_i
);

  localparam int LANES = 2;

  logic             arb_l_busy_n, arb_r_busy_n, collide;
  logic             l_allow, r_allow;
  logic [LANES-1:0] l_we, r_we;

  dpb_arbiter #(.ADDR_W(ADDR_W)) arb_i (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_addr(l_addr),
    .r_en_n(r_en_n), .r_addr(r_addr),
    .l_busy_n(arb_l_busy_n), .r_busy_n(arb_r_busy_n),
    .collide(collide)
  );

  if (IS_MASTER) begin : g_master
    logic unused_busy_in;
    assign unused_busy_in = l_busy_n_i ^ r_busy_n_i ^ collide;
    assign l_allow    = arb_l_busy_n;
    assign r_allow    = arb_r_busy_n;
    assign l_busy_n_o = arb_l_busy_n;
    assign r_busy_n_o = arb_r_busy_n;
  end else begin : g_slave
    logic unused_arb;
    assign unused_arb = arb_l_busy_n ^ arb_r_busy_n ^ collide;
    assign l_allow    = l_busy_n_i;
    assign r_allow    = r_busy_n_i;
    assign l_busy_n_o = 1'b1;
    assign r_busy_n_o = 1'b1;
  end

  dpb_port_ctrl l_ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .en_n(l_en_n), .oe_n(l_oe_n), .wr_lo_n(l_wr_lo_n), .wr_hi_n(l_wr_hi_n),
    .wr_allow(l_allow), .we(l_we),
    .rvld_lo(l_rvld_lo), .rvld_hi(l_rvld_hi), .rd_suspect(l_rd_suspect)
  );

  dpb_port_ctrl r_ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .en_n(r_en_n), .oe_n(r_oe_n), .wr_lo_n(r_wr_lo_n), .wr_hi_n(r_wr_hi_n),
    .wr_allow(r_allow), .we(r_we),
    .rvld_lo(r_rvld_lo), .rvld_hi(r_rvld_hi), .rd_suspect(r_rd_suspect)
  );

  dpb_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) array_i (
    .clk(clk),
    .l_addr(l_addr), .l_rd(!l_en_n), .l_we(l_we), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_addr(r_addr), .r_rd(!r_en_n), .r_we(r_we), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // R9 and R10: an inhibited port never reaches the array
  a_r9_left_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    !l_allow |-> (l_we == '0));
  a_r9_right_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    !r_allow |-> (r_we == '0));

endmodule

// File: tb/dpram_busy_arb_tb_top.sv
module dpram_busy_arb_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic        l_en_n, l_oe_n, l_wlo_n, l_whi_n, r_en_n, r_oe_n, r_wlo_n, r_whi_n;
  logic [10:0] l_addr, r_addr;
  logic [15:0] l_wd, r_wd;
  logic        s_busy_l, s_busy_r;

  logic [15:0] m_l_rd, m_r_rd, s_l_rd, s_r_rd;
  logic m_l_vlo, m_l_vhi, m_l_sus, m_l_bsy, m_r_vlo, m_r_vhi, m_r_sus, m_r_bsy;
  logic s_l_vlo, s_l_vhi, s_l_sus, s_l_bsy, s_r_vlo, s_r_vhi, s_r_sus, s_r_bsy;

  dpram_busy_arb dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_oe_n(l_oe_n), .l_wr_lo_n(l_wlo_n), .l_wr_hi_n(l_whi_n),
    .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(m_l_rd), .l_rvld_lo(m_l_vlo),
    .l_rvld_hi(m_l_vhi), .l_rd_suspect(m_l_sus), .l_busy_n_o(m_l_bsy), .l_busy_n_i(1'b0),
    .r_en_n(r_en_n), .r_oe_n(r_oe_n), .r_wr_lo_n(r_wlo_n), .r_wr_hi_n(r_whi_n),
    .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(m_r_rd), .r_rvld_lo(m_r_vlo),
    .r_rvld_hi(m_r_vhi), .r_rd_suspect(m_r_sus), .r_busy_n_o(m_r_bsy), .r_busy_n_i(1'b0)
  );

  dpram_busy_arb #(.IS_MASTER(1'b0)) dut_slave_i (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_oe_n(l_oe_n), .l_wr_lo_n(l_wlo_n), .l_wr_hi_n(l_whi_n),
    .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(s_l_rd), .l_rvld_lo(s_l_vlo),
    .l_rvld_hi(s_l_vhi), .l_rd_suspect(s_l_sus), .l_busy_n_o(s_l_bsy), .l_busy_n_i(s_busy_l),
    .r_en_n(r_en_n), .r_oe_n(r_oe_n), .r_wr_lo_n(r_wlo_n), .r_wr_hi_n(r_whi_n),
    .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(s_r_rd), .r_rvld_lo(s_r_vlo),
    .r_rvld_hi(s_r_vhi), .r_rd_suspect(s_r_sus), .r_busy_n_o(s_r_bsy), .r_busy_n_i(s_busy_r)
  );

  int checks = 0, fails = 0;
  int m_lo[int], m_hi[int];
  int pl_en, pl_addr, pr_en, pr_addr, loser;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lset(bit en, bit oe, bit wlo, bit whi, int a, int d);
    l_en_n = en; l_oe_n = oe; l_wlo_n = wlo; l_whi_n = whi; l_addr = 11'(a); l_wd = 16'(d);
  endtask
  task automatic rset(bit en, bit oe, bit wlo, bit whi, int a, int d);
    r_en_n = en; r_oe_n = oe; r_wlo_n = wlo; r_whi_n = whi; r_addr = 11'(a); r_wd = 16'(d);
  endtask
  task automatic idle();
    lset(1, 1, 1, 1, 0, 0); rset(1, 1, 1, 1, 0, 0);
  endtask

  // One clock: busy checked before the edge, registered reads after it.
  task automatic cyc();
    bit match, lnew, rnew, eb_l, eb_r, lvlo, lvhi, rvlo, rvhi, lsus, rsus;
    int nxt, la, ra, lxlo, lxhi, rxlo, rxhi;
    #1;
    la = int'(l_addr); ra = int'(r_addr);
    match = !l_en_n && !r_en_n && (la == ra);
    lnew = (int'(l_en_n) != pl_en) || (la != pl_addr);
    rnew = (int'(r_en_n) != pr_en) || (ra != pr_addr);
    if (!match) nxt = 0;
    else if (!lnew && !rnew) nxt = loser;
    else if (lnew && !rnew) nxt = 1;
    else nxt = 2;
    eb_l = (nxt != 1); eb_r = (nxt != 2);
    chk("R6 left busy", m_l_bsy, eb_l);
    chk("R6 right busy", m_r_bsy, eb_r);
    chk("R8 both busy low", (!m_l_bsy && !m_r_bsy), 0);
    lvlo = !l_en_n && l_wlo_n && !l_oe_n; lvhi = !l_en_n && l_whi_n && !l_oe_n;
    rvlo = !r_en_n && r_wlo_n && !r_oe_n; rvhi = !r_en_n && r_whi_n && !r_oe_n;
    lsus = (lvlo || lvhi) && !eb_l; rsus = (rvlo || rvhi) && !eb_r;
    lxlo = m_lo.exists(la) ? m_lo[la] : -1; lxhi = m_hi.exists(la) ? m_hi[la] : -1;
    rxlo = m_lo.exists(ra) ? m_lo[ra] : -1; rxhi = m_hi.exists(ra) ? m_hi[ra] : -1;
    @(posedge clk);
    if (!l_en_n && eb_l) begin
      if (!l_wlo_n) m_lo[la] = int'(l_wd[7:0]);
      if (!l_whi_n) m_hi[la] = int'(l_wd[15:8]);
    end
    if (!r_en_n && eb_r) begin
      if (!r_wlo_n) m_lo[ra] = int'(r_wd[7:0]);
      if (!r_whi_n) m_hi[ra] = int'(r_wd[15:8]);
    end
    pl_en = int'(l_en_n); pl_addr = la; pr_en = int'(r_en_n); pr_addr = ra; loser = nxt;
    @(negedge clk);
    chk("R3 left lo valid", m_l_vlo, lvlo);  chk("R3 left hi valid", m_l_vhi, lvhi);
    chk("R3 right lo valid", m_r_vlo, rvlo); chk("R3 right hi valid", m_r_vhi, rvhi);
    chk("R11 left suspect", m_l_sus, lsus);  chk("R11 right suspect", m_r_sus, rsus);
    if (lvlo && !lsus && lxlo >= 0) chk("R1 left lo data", m_l_rd[7:0], lxlo);
    if (lvhi && !lsus && lxhi >= 0) chk("R1 left hi data", m_l_rd[15:8], lxhi);
    if (rvlo && !rsus && rxlo >= 0) chk("R1 right lo data", m_r_rd[7:0], rxlo);
    if (rvhi && !rsus && rxhi >= 0) chk("R1 right hi data", m_r_rd[15:8], rxhi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pl_en = 1; pl_addr = 0; pr_en = 1; pr_addr = 0; loser = 0;
    s_busy_l = 1'b1; s_busy_r = 1'b1;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset valid", {m_l_vlo, m_l_vhi, m_r_vlo, m_r_vhi}, 0);
    chk("R5 reset busy", {m_l_bsy, m_r_bsy}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: full word writes from both ports, read back
    lset(0, 1, 0, 0, 10, 16'hA1B2); rset(0, 1, 0, 0, 20, 16'hC3D4); cyc();
    lset(0, 0, 1, 1, 20, 0); rset(0, 0, 1, 1, 10, 0); cyc();
    chk("R1 left reads right's word", m_l_rd, 16'hC3D4);
    chk("R1 right reads left's word", m_r_rd, 16'hA1B2);
    chk("R5 different addresses", {m_l_bsy, m_r_bsy}, 2'b11);

    // R4: write low byte, read high byte in one access, then the reverse
    lset(0, 0, 0, 1, 10, 16'h0077); idle_r(); cyc();
    chk("R4 high byte read", m_l_rd[15:8], 8'hA1);
    chk("R4 only high valid", {m_l_vlo, m_l_vhi}, 2'b01);
    lset(0, 0, 1, 0, 10, 16'h5500); cyc();
    chk("R4 low byte read shows new write", m_l_rd[7:0], 8'h77);
    lset(0, 0, 1, 1, 10, 0); cyc();
    chk("R4 merged word", m_l_rd, 16'h5577);

    // R3: output enable high hides the read
    lset(0, 1, 1, 1, 10, 0); cyc();
    chk("R3 oe high no valid", {m_l_vlo, m_l_vhi}, 0);

    // R2: disabled port with write strobes low does nothing
    lset(1, 0, 0, 0, 10, 16'hFFFF); cyc();
    chk("R2 disabled no valid", {m_l_vlo, m_l_vhi}, 0);
    lset(0, 0, 1, 1, 10, 0); cyc();
    chk("R2 word unchanged", m_l_rd, 16'h5577);

    // R5: same address but one port disabled
    lset(0, 0, 1, 1, 10, 0); rset(1, 0, 1, 1, 10, 0); #1;
    chk("R5 one disabled", {m_l_bsy, m_r_bsy}, 2'b11);
    cyc();

    // R6/R9: left holds 30, right arrives later with a write
    idle(); lset(0, 1, 0, 0, 30, 16'h5A5A); cyc();
    lset(0, 0, 1, 1, 30, 0); cyc();
    rset(0, 1, 0, 0, 30, 16'hBEEF); cyc();
    chk("R6 later right is busy", m_r_bsy, 0);
    chk("R6 earlier left stays free", m_l_bsy, 1);
    cyc(); cyc();
    chk("R6 busy held", m_r_bsy, 0);
    rset(0, 1, 0, 0, 31, 16'h1111); #1;
    chk("R6 busy released when match ends", m_r_bsy, 1);
    cyc();
    idle(); lset(0, 0, 1, 1, 30, 0); cyc();
    chk("R9 dropped write leaves word", m_l_rd, 16'h5A5A);

    // R7: simultaneous arrival
    idle(); cyc();
    lset(0, 1, 0, 0, 40, 16'h4444); rset(0, 1, 0, 0, 40, 16'h9999); cyc();
    chk("R7 right busy on tie", m_r_bsy, 0);
    chk("R7 left free on tie", m_l_bsy, 1);
    chk("R10 slave busy out high", s_r_bsy, 1);
    rset(0, 0, 1, 1, 40, 0); cyc();
    chk("R11 busy read suspect", m_r_sus, 1);
    idle(); lset(0, 0, 1, 1, 40, 0); cyc();
    chk("R7 winner's write kept", m_l_rd, 16'h4444);

    // R6: left arrives later
    idle(); rset(0, 1, 0, 0, 50, 16'h7777); cyc();
    rset(0, 0, 1, 1, 50, 0); lset(0, 1, 0, 0, 50, 16'h0001); cyc();
    chk("R6 later left is busy", m_l_bsy, 0);
    chk("R6 earlier right free", m_r_bsy, 1);
    idle(); rset(0, 0, 1, 1, 50, 0); cyc();
    chk("R9 left write dropped", m_r_rd, 16'h7777);

    // R10: slave inhibit by busy input; master ignores its busy inputs
    idle(); lset(0, 1, 0, 0, 100, 16'h1234); cyc();
    s_busy_l = 1'b0; lset(0, 1, 0, 0, 100, 16'hDEAD); cyc();
    s_busy_l = 1'b1; lset(0, 0, 1, 1, 100, 0); cyc();
    chk("R10 slave write inhibited", s_l_rd, 16'h1234);
    chk("R10 master ignores busy input", m_l_rd, 16'hDEAD);
    chk("R10 slave left busy out high", s_l_bsy, 1);

    // Random traffic over four addresses to force collisions
    for (int i = 0; i < 400; i++) begin
      lset(($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4, $urandom);
      if (($urandom % 3) != 0)
        rset(($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4, $urandom);
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic idle_r();
    rset(1, 1, 1, 1, 0, 0);
  endtask

endmodule